// File: doc/BRIEF.md
# Boot Vector Remap Selector

This block sits in front of the instruction and data read path and decides which memory answers a read of the first four vector words of the address space. It holds a 2-bit mapping field. The field picks one of three sources for those words: the bootloader area, a set of boot vectors held in SRAM, or main flash. While reset is asserted, the field is loaded from two boot strap pins. Software can rewrite it later through a small configuration write port, for example to reach the flash vectors while running from the bootloader.

For each read address, the block reports whether the address falls in the vector window, which source should serve it, and the translated address in that source. A window hit adds the byte offset inside the window to a parameterised base for the selected source. Any read outside the window goes to flash with its address unchanged. The parameter `SRAM_EN` removes the SRAM mode. When it is 0, the low strap pin is not used and the field can never hold code 01.

Top module: `vec_remap_sel`

## Requirements
- R1: While `rst_n` is low the mapping field loads `{strap_hi, strap_lo}` on every clock edge. After `rst_n` goes high, changes on the strap pins no longer affect it.
- R2: With field code 00, a read inside the window gives `src_sel` = 1 (bootloader) and `map_addr` = `BOOT_BASE` + (`rd_addr` mod window size).
- R3: With field code 01 and `SRAM_EN` = 1, a read inside the window gives `src_sel` = 2 (SRAM) and `map_addr` = `SRAM_BASE` + offset.
- R4: With field code 10 or 11, a read inside the window gives `src_sel` = 0 (flash) and `map_addr` = `FLASH_BASE` + offset.
- R5: `vec_hit` is 1 exactly when `rd_addr` < 4·`VEC_WORDS`, which is byte addresses 0x0 to 0xF by default.
- R6: For a read outside the window, `vec_hit` = 0, `src_sel` = 0 and `map_addr` equals `rd_addr`, whatever the field holds.
- R7: A write with `cfg_we` = 1 and `cfg_addr` = `CFG_OFFSET` (0x100 by default) stores `cfg_wdata[1:0]` into the field. The new value is visible on `cfg_rdata[1:0]` and in the translation from the next cycle on. The upper bits of `cfg_rdata` read 0.
- R8: A write to any other `cfg_addr` leaves the field unchanged, and the field holds its value between writes.
- R9: With `SRAM_EN` = 0, bit 0 of the field is always 0: `strap_lo` and `cfg_wdata[0]` are ignored, and code 01 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or system), samples the straps |
| strap_hi | input | 1 | High boot strap pin, bit 1 of the field |
| strap_lo | input | 1 | Low boot strap pin, bit 0 of the field (unused when SRAM_EN = 0) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register offset |
| cfg_wdata | input | CFG_DW | Configuration write data, field in bits [1:0] |
| cfg_rdata | output | CFG_DW | Current field, zero-extended |
| rd_addr | input | ADDR_W | Incoming read address |
| vec_hit | output | 1 | Read falls in the vector window |
| src_sel | output | 2 | Source: 0 flash, 1 bootloader, 2 SRAM |
| map_addr | output | ADDR_W | Translated read address |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default parameters with `SRAM_EN` = 1, so all four field codes and the SRAM source can be reached. The other sets `SRAM_EN` = 0, so writes and strap patterns with a set low bit can be shown to collapse onto flash or bootloader mapping. Both copies use distinct nonzero bases for every source, including flash, so an offset that is dropped or added to the wrong base changes `map_addr`. Reads are aimed at both sides of the window edge at 0xF/0x10.

// File: rtl/vec_remap_pkg.sv
package vec_remap_pkg;
   typedef enum logic [1:0] {
      SRC_FLASH = 2'd0,
      SRC_BOOT  = 2'd1,
      SRC_SRAM  = 2'd2
   } vsrc_e;

   localparam logic [1:0] MODE_BOOT  = 2'b00;
   localparam logic [1:0] MODE_SRAM  = 2'b01;
endpackage

// File: rtl/vec_remap_mode_reg.sv
module vec_remap_mode_reg #(
   parameter int          CFG_AW     = 12,
   parameter int          CFG_DW     = 32,
   parameter logic [11:0] CFG_OFFSET = 12'h100,
   parameter bit          SRAM_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_hi,
   input  logic              strap_lo,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [1:0]        mode
);
   localparam logic [CFG_AW-1:0] SEL_ADDR = CFG_AW'(CFG_OFFSET);

   logic strap_lo_eff;
   logic wr_lo_eff;
   logic sel_hit;

   generate
      if (SRAM_EN) begin : g_sram_on
         assign strap_lo_eff = strap_lo;
         assign wr_lo_eff    = cfg_wdata[0];
      end else begin : g_sram_off
         assign strap_lo_eff = 1'b0;
         assign wr_lo_eff    = 1'b0;
      end
   endgenerate

   assign sel_hit = cfg_we && (cfg_addr == SEL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= {strap_hi, strap_lo_eff};
      end else if (sel_hit) begin
         mode <= {cfg_wdata[1], wr_lo_eff};
      end
   end
endmodule

// File: rtl/vec_remap_xlate.sv
module vec_remap_xlate
   import vec_remap_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                VEC_WORDS  = 4,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = '0,
   parameter logic [ADDR_W-1:0] SRAM_BASE  = '0,
   parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
   parameter bit                SRAM_EN    = 1'b1
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              vec_hit,
   output logic [1:0]        src_sel,
   output logic [ADDR_W-1:0] map_addr
);
   localparam int OFF_W = $clog2(VEC_WORDS * 4);

   logic [ADDR_W-1:0] offset;
   vsrc_e             win_src;
   logic [ADDR_W-1:0] win_base;

   assign vec_hit = (rd_addr[ADDR_W-1:OFF_W] == '0);
   assign offset  = {{(ADDR_W-OFF_W){1'b0}}, rd_addr[OFF_W-1:0]};

   generate
      if (SRAM_EN) begin : g_dec_full
         always_comb begin
            unique case (mode)
               MODE_BOOT: win_src = SRC_BOOT;
               MODE_SRAM: win_src = SRC_SRAM;
               default:   win_src = SRC_FLASH;
            endcase
         end
      end else begin : g_dec_nosram
         always_comb begin
            win_src = (mode[1] == 1'b0) ? SRC_BOOT : SRC_FLASH;
         end
      end
   endgenerate

   always_comb begin
      unique case (win_src)
         SRC_BOOT: win_base = BOOT_BASE;
         SRC_SRAM: win_base = SRAM_BASE;
         default:  win_base = FLASH_BASE;
      endcase
   end

   always_comb begin
      if (vec_hit) begin
         src_sel  = win_src;
         map_addr = win_base + offset;
      end else begin
         src_sel  = SRC_FLASH;
         map_addr = rd_addr;
      end
   end
endmodule

// File: rtl/vec_remap_sel.sv
module vec_remap_sel #(
   parameter int                ADDR_W     = 32,
   parameter int                VEC_WORDS  = 4,
   parameter int                CFG_AW     = 12,
   parameter int                CFG_DW     = 32,
   parameter logic [11:0]       CFG_OFFSET = 12'h100,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = ADDR_W'(32'h1F00_0000),
   parameter logic [ADDR_W-1:0] SRAM_BASE  = ADDR_W'(32'h2000_0000),
   parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
   parameter bit                SRAM_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_hi,
   input  logic              strap_lo,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              vec_hit,
   output logic [1:0]        src_sel,
   output logic [ADDR_W-1:0] map_addr
);
   localparam int WIN_BYTES = VEC_WORDS * 4;
   localparam int OFF_W     = $clog2(WIN_BYTES);

   generate
      if (VEC_WORDS < 1 || (VEC_WORDS & (VEC_WORDS - 1)) != 0) begin : g_bad_words
         $error("VEC_WORDS must be a power of two");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_aw
         $error("ADDR_W too small for the vector window");
      end
      if (CFG_DW < 2 || CFG_AW < 1 || CFG_AW > 12) begin : g_bad_cfg
         $error("configuration port widths out of range");
      end
   endgenerate

   logic [1:0] mode;

   vec_remap_mode_reg #(
      .CFG_AW    (CFG_AW),
      .CFG_DW    (CFG_DW),
      .CFG_OFFSET(CFG_OFFSET),
      .SRAM_EN   (SRAM_EN)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_hi (strap_hi),
      .strap_lo (strap_lo),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .mode     (mode)
   );

   vec_remap_xlate #(
      .ADDR_W    (ADDR_W),
      .VEC_WORDS (VEC_WORDS),
      .BOOT_BASE (BOOT_BASE),
      .SRAM_BASE (SRAM_BASE),
      .FLASH_BASE(FLASH_BASE),
      .SRAM_EN   (SRAM_EN)
   ) u_xlate (
      .mode    (mode),
      .rd_addr (rd_addr),
      .vec_hit (vec_hit),
      .src_sel (src_sel),
      .map_addr(map_addr)
   );

   assign cfg_rdata = {{(CFG_DW-2){1'b0}}, mode};
endmodule

// File: rtl/vec_remap_sel_chk.sv
module vec_remap_sel_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                VEC_WORDS  = 4,
   parameter int                CFG_AW     = 12,
   parameter int                CFG_DW     = 32,
   parameter logic [11:0]       CFG_OFFSET = 12'h100,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = '0,
   parameter logic [ADDR_W-1:0] SRAM_BASE  = '0,
   parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
   parameter bit                SRAM_EN    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_hi,
   input logic              strap_lo,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [CFG_DW-1:0] cfg_wdata,
   input logic [CFG_DW-1:0] cfg_rdata,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              vec_hit,
   input logic [1:0]        src_sel,
   input logic [ADDR_W-1:0] map_addr
);
   localparam logic [ADDR_W-1:0] WIN = ADDR_W'(VEC_WORDS * 4);
   localparam logic [CFG_AW-1:0] SEL = CFG_AW'(CFG_OFFSET);

   logic wr_sel;
   assign wr_sel = cfg_we && (cfg_addr == SEL);

   AST_STRAP_LOAD: assert property (@(posedge clk)
      !rst_n |=> cfg_rdata[1] == $past(strap_hi));                      // R1

   AST_WINDOW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_hit == (rd_addr < WIN));                                      // R5

   AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_hit |-> (map_addr == rd_addr && src_sel == 2'd0));           // R6

   AST_BOOT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_hit && cfg_rdata[1:0] == 2'b00) |-> src_sel == 2'd1);        // R2

   AST_FLASH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_hit && cfg_rdata[1]) |-> src_sel == 2'd0);                   // R4

   AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> cfg_rdata[1] == $past(cfg_wdata[1]));                  // R7

   AST_HOLD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !wr_sel) |=> $stable(cfg_rdata));                       // R8

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CFG_DW-1:2] == '0);                                     // R7

   generate
      if (SRAM_EN) begin : g_sram_chk
         AST_SRAM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_hit && cfg_rdata[1:0] == 2'b01) |-> src_sel == 2'd2);  // R3
      end else begin : g_nosram_chk
         AST_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_rdata[0] == 1'b0 && src_sel != 2'd2);                   // R9
      end
   endgenerate
endmodule

bind vec_remap_sel vec_remap_sel_chk #(
   .ADDR_W    (ADDR_W),
   .VEC_WORDS (VEC_WORDS),
   .CFG_AW    (CFG_AW),
   .CFG_DW    (CFG_DW),
   .CFG_OFFSET(CFG_OFFSET),
   .BOOT_BASE (BOOT_BASE),
   .SRAM_BASE (SRAM_BASE),
   .FLASH_BASE(FLASH_BASE),
   .SRAM_EN   (SRAM_EN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strap_hi (strap_hi),
   .strap_lo (strap_lo),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata),
   .rd_addr  (rd_addr),
   .vec_hit  (vec_hit),
   .src_sel  (src_sel),
   .map_addr (map_addr)
);

// File: tb/vec_remap_sel_tb.sv
module vec_remap_sel_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] B_BOOT  = 32'h1F00_0000;
   localparam logic [31:0] B_SRAM  = 32'h2000_0100;
   localparam logic [31:0] B_FLASH = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_hi = 1'b0, strap_lo = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] rd_addr = '0;
   logic [31:0] rdata_a, rdata_b, map_a, map_b;
   logic        hit_a, hit_b;
   logic [1:0]  src_a, src_b;

   logic [1:0]  m_a, m_b;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_remap_sel #(.BOOT_BASE(B_BOOT), .SRAM_BASE(B_SRAM), .FLASH_BASE(B_FLASH),
                   .SRAM_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a),
      .rd_addr(rd_addr), .vec_hit(hit_a), .src_sel(src_a), .map_addr(map_a));

   vec_remap_sel #(.BOOT_BASE(B_BOOT), .SRAM_BASE(B_SRAM), .FLASH_BASE(B_FLASH),
                   .SRAM_EN(1'b0)) u_dut_nosram (
      .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b),
      .rd_addr(rd_addr), .vec_hit(hit_b), .src_sel(src_b), .map_addr(map_b));

   function automatic logic [1:0] exp_src(logic [1:0] m, logic [31:0] a);
      if (a >= 32'd16) return 2'd0;
      case (m)
         2'b00:   return 2'd1;
         2'b01:   return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [31:0] exp_map(logic [1:0] m, logic [31:0] a);
      if (a >= 32'd16) return a;
      case (m)
         2'b00:   return B_BOOT + a;
         2'b01:   return B_SRAM + a;
         default: return B_FLASH + a;
      endcase
   endfunction

   function automatic string tag_of(logic [1:0] m, logic [31:0] a);
      if (a >= 32'd16) return "R6";
      case (m)
         2'b00:   return "R2";
         2'b01:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset(logic hi, logic lo);
      @(negedge clk);
      rst_n = 1'b0; strap_hi = hi; strap_lo = lo;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_a = {hi, lo};
      m_b = {hi, 1'b0};
      strap_hi = ~hi; strap_lo = ~lo;
      @(negedge clk);
      #1;
      check("R1", "field after reset", rdata_a, {30'd0, m_a});
      check("R9", "field after reset, no SRAM", rdata_b, {30'd0, m_b});
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
      if (a == 12'h100) begin
         m_a = d[1:0];
         m_b = {d[1], 1'b0};
      end
      #1;
      check(a == 12'h100 ? "R7" : "R8", "readback", rdata_a, {30'd0, m_a});
      check(a == 12'h100 ? "R9" : "R8", "readback, no SRAM", rdata_b, {30'd0, m_b});
   endtask

   task automatic do_read(logic [31:0] a);
      rd_addr = a;
      #1;
      check("R5", "vec_hit", {31'd0, hit_a}, {31'd0, a < 32'd16});
      check(tag_of(m_a, a), "src_sel", {30'd0, src_a}, {30'd0, exp_src(m_a, a)});
      check(tag_of(m_a, a), "map_addr", map_a, exp_map(m_a, a));
      check("R9", "src_sel, no SRAM", {30'd0, src_b}, {30'd0, exp_src(m_b, a)});
      check("R9", "map_addr, no SRAM", map_b, exp_map(m_b, a));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      // R1 each strap pattern, then reads at the window boundaries
      for (int p = 0; p < 4; p++) begin
         do_reset(p[1], p[0]);
         do_read(32'h0); do_read(32'h4); do_read(32'hC); do_read(32'hF);
         do_read(32'h10); do_read(32'hFFFF_FFFC);
      end
      // R7 every code through the write port
      for (int c = 0; c < 4; c++) begin
         do_write(12'h100, 32'hFFFF_FFFC | c);
         do_read(32'h8); do_read(32'h11);
      end
      // R8 writes to neighbouring offsets are ignored
      do_write(12'h100, 32'h1);
      do_write(12'h104, 32'h2);
      do_write(12'h000, 32'h3);
      do_read(32'h4);
      // R9 strap_lo ignored and 01 written collapses to bootloader
      do_reset(1'b0, 1'b1);
      do_read(32'h0);
      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         if (($urandom % 4) == 0)
            do_write(($urandom % 2) ? 12'h100 : 12'($urandom), $urandom);
         a = ($urandom % 2) ? ($urandom % 32'd20) : $urandom;
         do_read(a);
      end
      finish_run();
   end
endmodule